// File: doc/BRIEF.md
# Stereo Attenuation Register Bank with Deferred Commit

This block holds the control state for a two-channel output attenuator. A plain register write port carries a 7-bit address and a 9-bit data word. Writes fill a pending stage, and gain outputs are driven only from an active stage. Each channel keeps a 7-bit attenuation code in both stages. A master address writes the same code into both pending slots in one transaction.

Data bit 8 on a channel or master write requests a commit. This bit is never stored. After a request, both channels copy their pending codes into the active stage on the first sample strobe that follows the write. A channel whose zero-cross enable is set (its own or the master one) then waits for its zero-crossing pulse. A strobe counter forces that channel's commit if no pulse arrives. The block also holds a power-down bit and offers a combinational read-back port. Codes run from 127 (+6 dB) down in 1 dB steps to 48 (-73 dB). Codes below 48 raise a mute flag.

Top module: `stereo_atten_regs`

## Requirements
- R1: After reset both gain outputs are 121 (binary 1111001, 0 dB), both mute flags are 0, powerDown is 1, read-back of addresses 0, 1 and 2 returns 0x079 and address 13 returns 0x008.
- R2: A write to address 0 (left) or 1 (right) with data bit 8 clear stores data bits 6:0 in that channel's pending code and leaves the gain outputs unchanged, even across later sample strobes.
- R3: A write to address 0, 1 or 2 with data bit 8 set requests a commit. On the first sample strobe in a later cycle than that write, every channel without zero-cross enable copies its pending code to its gain output, and the output is visible after that edge. A strobe in the same cycle as the write does not commit.
- R4: A write to address 2 (master) loads data bits 6:0 into both pending codes, replaces earlier per-channel values, and is returned by read-back of addresses 0, 1 and 2.
- R5: Read-back returns {0, zero-cross enable, pending code}. The enable is data bit 7 as last written to that address, and bit 8 always reads 0.
- R6: A channel whose own enable or the master enable is set does not change at the commit strobe. It commits on its own zero-cross pulse (zcPulseL for left, zcPulseR for right), visible after that edge. A pulse for the other channel has no effect on it.
- R7: A waiting channel that gets no pulse commits on the 1024th sample strobe after the strobe that armed it.
- R8: A waiting channel commits the pending code held at the moment of commit, including writes made after the request.
- R9: muteL/muteR are 1 exactly when the corresponding gain output is below 48. A gain of 48 is not muted.
- R10: Address 13 data bit 3 sets powerDown, which reads back at bit 3 of address 13.
- R11: Writes to other addresses change no state and read back as 0. Zero-cross pulses with no waiting channel, and sample strobes with no request, leave the gains unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 7 | Write address |
| wrData | input | 9 | Write data |
| rdAddr | input | 7 | Read-back address |
| rdData | output | 9 | Read-back data (combinational) |
| sampleStb | input | 1 | One-cycle sample strobe |
| zcPulseL | input | 1 | Left zero-crossing pulse |
| zcPulseR | input | 1 | Right zero-crossing pulse |
| gainL | output | 7 | Active left attenuation code |
| gainR | output | 7 | Active right attenuation code |
| muteL | output | 1 | Left mute flag |
| muteR | output | 1 | Right mute flag |
| powerDown | output | 1 | Output power-down |

## Verification
Read-back is combinational on the pending stage. A written value is therefore due right after the write's clock edge, and the bench checks it in the low phase of that same cycle. A gain output moves on the edge that samples the committing strobe or zero-cross pulse. The bench drives each such event for exactly one cycle and pushes its expected gains right after that edge. It also pushes gains before that edge, so a design that commits early or at a same-cycle strobe is caught. The timeout case counts 1023 strobes with the gain held and expects the new code after the 1024th.

// File: rtl/atten_pkg.sv
`timescale 1ns/1ps
package atten_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 9;
  localparam int CODE_W = 7;
  localparam int NUM_CH = 2;

  localparam logic [CODE_W-1:0] RESET_CODE = 7'b1111001;
  localparam logic [CODE_W-1:0] MUTE_BELOW = 7'd48;

  localparam logic [ADDR_W-1:0] ADR_LEFT   = 7'd0;
  localparam logic [ADDR_W-1:0] ADR_RIGHT  = 7'd1;
  localparam logic [ADDR_W-1:0] ADR_MASTER = 7'd2;
  localparam logic [ADDR_W-1:0] ADR_PWR    = 7'd13;

  localparam int ZC_BIT  = 7;
  localparam int UPD_BIT = 8;
  localparam int PD_BIT  = 3;

  typedef struct packed {
    logic              ldLeft;
    logic              ldRight;
    logic              ldMaster;
    logic              ldPwr;
    logic              apply;
    logic              tick;
    logic [CODE_W-1:0] code;
    logic              zcBit;
    logic              pdBit;
  } ctlStrb_t;
endpackage

// File: rtl/atten_ctrl.sv
`timescale 1ns/1ps
module atten_ctrl
  import atten_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sampleStb,
  output ctlStrb_t          strb
);
  logic reqPend;
  logic hitLeft, hitRight, hitMaster, hitPwr, reqNew;

  always_comb begin
    hitLeft   = wrEn && (wrAddr == ADR_LEFT);
    hitRight  = wrEn && (wrAddr == ADR_RIGHT);
    hitMaster = wrEn && (wrAddr == ADR_MASTER);
    hitPwr    = wrEn && (wrAddr == ADR_PWR);
    reqNew    = (hitLeft || hitRight || hitMaster) && wrData[UPD_BIT];
  end

  // a request raised in this cycle waits for a strobe in a later cycle
  always_ff @(posedge clk) begin
    if (!rstN) reqPend <= 1'b0;
    else       reqPend <= reqNew || (reqPend && !sampleStb);
  end

  always_comb begin
    strb.ldLeft   = hitLeft;
    strb.ldRight  = hitRight;
    strb.ldMaster = hitMaster;
    strb.ldPwr    = hitPwr;
    strb.apply    = sampleStb && reqPend;
    strb.tick     = sampleStb;
    strb.code     = wrData[CODE_W-1:0];
    strb.zcBit    = wrData[ZC_BIT];
    strb.pdBit    = wrData[PD_BIT];
  end
endmodule

// File: rtl/atten_datapath.sv
`timescale 1ns/1ps
module atten_datapath
  import atten_pkg::*;
#(
  parameter int TIMEOUT_STROBES = 1024
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrb_t                       strb,
  input  logic [NUM_CH-1:0]              zcPulse,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_CH-1:0][CODE_W-1:0]  gain,
  output logic [NUM_CH-1:0]              mute,
  output logic                           pwrDown
);
  localparam int CNT_W = (TIMEOUT_STROBES > 1) ? $clog2(TIMEOUT_STROBES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_STROBES - 1);

  logic [NUM_CH-1:0][CODE_W-1:0] preCode;
  logic [NUM_CH-1:0]             zcEn;
  logic [CODE_W-1:0]             mstCode;
  logic                          zcEnMst;

  // pending stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCode <= {NUM_CH{RESET_CODE}};
      zcEn    <= '0;
      mstCode <= RESET_CODE;
      zcEnMst <= 1'b0;
      pwrDown <= 1'b1;
    end else begin
      if (strb.ldMaster) begin
        preCode <= {NUM_CH{strb.code}};
        mstCode <= strb.code;
        zcEnMst <= strb.zcBit;
      end
      if (strb.ldLeft) begin
        preCode[0] <= strb.code;
        zcEn[0]    <= strb.zcBit;
      end
      if (strb.ldRight) begin
        preCode[1] <= strb.code;
        zcEn[1]    <= strb.zcBit;
      end
      if (strb.ldPwr) pwrDown <= strb.pdBit;
    end
  end

  // active stage, one commit engine per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic             waiting;
    logic [CNT_W-1:0] strobeCnt;
    logic             zcEff;

    assign zcEff = zcEn[ch] || zcEnMst;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        gain[ch]  <= RESET_CODE;
        waiting   <= 1'b0;
        strobeCnt <= '0;
      end else if (strb.apply) begin
        if (zcEff) begin
          waiting   <= 1'b1;
          strobeCnt <= '0;
        end else begin
          gain[ch] <= preCode[ch];
          waiting  <= 1'b0;
        end
      end else if (waiting) begin
        if (zcPulse[ch]) begin
          gain[ch] <= preCode[ch];
          waiting  <= 1'b0;
        end else if (strb.tick) begin
          if (strobeCnt == CNT_LAST) begin
            gain[ch] <= preCode[ch];
            waiting  <= 1'b0;
          end else begin
            strobeCnt <= strobeCnt + 1'b1;
          end
        end
      end
    end

    assign mute[ch] = (gain[ch] < MUTE_BELOW);
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_LEFT:   rdData = {1'b0, zcEn[0], preCode[0]};
      ADR_RIGHT:  rdData = {1'b0, zcEn[1], preCode[1]};
      ADR_MASTER: rdData = {1'b0, zcEnMst, mstCode};
      ADR_PWR:    rdData[PD_BIT] = pwrDown;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/stereo_atten_regs.sv
`timescale 1ns/1ps
module stereo_atten_regs
  import atten_pkg::*;
#(
  parameter int TIMEOUT_STROBES = 1024
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              sampleStb,
  input  logic              zcPulseL,
  input  logic              zcPulseR,
  output logic [CODE_W-1:0] gainL,
  output logic [CODE_W-1:0] gainR,
  output logic              muteL,
  output logic              muteR,
  output logic              powerDown
);
  ctlStrb_t                      strb;
  logic [NUM_CH-1:0][CODE_W-1:0] gainV;
  logic [NUM_CH-1:0]             muteV;

  atten_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .sampleStb(sampleStb), .strb(strb)
  );

  atten_datapath #(.TIMEOUT_STROBES(TIMEOUT_STROBES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .zcPulse({zcPulseR, zcPulseL}),
    .rdAddr(rdAddr), .rdData(rdData), .gain(gainV), .mute(muteV),
    .pwrDown(powerDown)
  );

  assign gainL = gainV[0];
  assign gainR = gainV[1];
  assign muteL = muteV[0];
  assign muteR = muteV[1];
endmodule

// File: rtl/atten_regs_chk.sv
`timescale 1ns/1ps
module atten_regs_chk
  import atten_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              sampleStb,
  input logic              zcPulseL,
  input logic              zcPulseR,
  input logic [CODE_W-1:0] gainL,
  input logic [CODE_W-1:0] gainR,
  input logic              muteL,
  input logic              muteR,
  input logic              powerDown
);
  // R3/R6: a gain moves only on an edge that saw a strobe or its own pulse
  a_r3_left_change_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainL) |-> ($past(sampleStb) || $past(zcPulseL)));
  a_r3_right_change_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainR) |-> ($past(sampleStb) || $past(zcPulseR)));
  // R9: mute flags track the active codes
  a_r9_mute_left: assert property (@(posedge clk) disable iff (!rstN)
    muteL == (gainL < MUTE_BELOW));
  a_r9_mute_right: assert property (@(posedge clk) disable iff (!rstN)
    muteR == (gainR < MUTE_BELOW));
  // R10: power-down changes only after a write to its address
  a_r10_pwr_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(powerDown) |-> $past(wrEn && (wrAddr == ADR_PWR)));
  // R5: the commit flag never reads back
  a_r5_upd_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[UPD_BIT] == 1'b0);
endmodule

bind stereo_atten_regs atten_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdData(rdData),
  .sampleStb(sampleStb), .zcPulseL(zcPulseL), .zcPulseR(zcPulseR),
  .gainL(gainL), .gainR(gainR), .muteL(muteL), .muteR(muteR),
  .powerDown(powerDown)
);

// File: tb/sim_stereo_atten_regs.sv
`timescale 1ns/1ps
module sim_stereo_atten_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [8:0] wrData = '0;
  logic [6:0] rdAddr = '0;
  logic [8:0] rdData;
  logic       sampleStb = 1'b0;
  logic       zcPulseL = 1'b0;
  logic       zcPulseR = 1'b0;
  logic [6:0] gainL, gainR;
  logic       muteL, muteR, powerDown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stereo_atten_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sampleStb(sampleStb),
    .zcPulseL(zcPulseL), .zcPulseR(zcPulseR), .gainL(gainL), .gainR(gainR),
    .muteL(muteL), .muteR(muteR), .powerDown(powerDown)
  );

  typedef struct {
    string req;
    int    kind;   // 0 gainL, 1 gainR, 2 muteL, 3 muteR, 4 powerDown, 5 rdData
    int    val;
  } expItem_t;

  expItem_t expQ[$];

  function automatic int observe(int kind);
    case (kind)
      0: return int'(gainL);
      1: return int'(gainR);
      2: return int'(muteL);
      3: return int'(muteR);
      4: return int'(powerDown);
      default: return int'(rdData);
    endcase
  endfunction

  // monitor: compares queued expectations in the low phase
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      int act;
      it  = expQ.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic expect_val(string req, int kind, int val);
    expItem_t it;
    it.req = req; it.kind = kind; it.val = val;
    expQ.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [8:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  task automatic strobe();
    sampleStb = 1'b1; step(); sampleStb = 1'b0;
  endtask

  task automatic zc(input logic l, input logic r);
    zcPulseL = l; zcPulseR = r; step(); zcPulseL = 1'b0; zcPulseR = 1'b0;
  endtask

  task automatic rd(string req, input logic [6:0] a, int expv);
    rdAddr = a; expect_val(req, 5, expv); step();
  endtask

  task automatic gains(string req, int l, int r);
    expect_val(req, 0, l); expect_val(req, 1, r); step();
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    // R1 reset state
    expect_val("R1", 0, 121); expect_val("R1", 1, 121);
    expect_val("R1", 2, 0); expect_val("R1", 3, 0); expect_val("R1", 4, 1);
    step();
    rd("R1", 7'd0, 'h079); rd("R1", 7'd1, 'h079); rd("R1", 7'd2, 'h079);
    rd("R1", 7'd13, 'h008);

    // R2 pending only
    wr(7'd0, 9'h050);
    rd("R2", 7'd0, 'h050);
    wr(7'd1, 9'h060);
    rd("R2", 7'd1, 'h060);
    strobe();
    gains("R2", 121, 121);

    // R3 commit on next strobe, R5 bit 8 reads 0
    wr(7'd0, 9'h146);
    rd("R5", 7'd0, 'h046);
    gains("R3", 121, 121);
    strobe();
    gains("R3", 'h46, 'h60);
    // R3 same-cycle strobe does not commit
    wrAddr = 7'd0; wrData = 9'h17F; wrEn = 1'b1; sampleStb = 1'b1;
    step();
    wrEn = 1'b0; sampleStb = 1'b0;
    gains("R3", 'h46, 'h60);
    strobe();
    gains("R3", 127, 'h60);

    // R4 master write
    wr(7'd2, 9'h064);
    rd("R4", 7'd0, 'h064); rd("R4", 7'd1, 'h064); rd("R4", 7'd2, 'h064);
    gains("R4", 127, 'h60);
    wr(7'd1, 9'h164);
    strobe();
    gains("R4", 100, 100);

    // R9 mute boundary
    wr(7'd0, 9'h02F);
    wr(7'd1, 9'h130);
    strobe();
    expect_val("R9", 2, 1); expect_val("R9", 3, 0);
    gains("R9", 47, 48);

    // R6 per-channel zero-cross wait
    wr(7'd0, 9'h0D0);
    wr(7'd1, 9'h15A);
    rd("R5", 7'd0, 'h0D0);
    strobe();
    gains("R6", 47, 90);
    repeat (3) step();
    gains("R6", 47, 90);
    zc(1'b0, 1'b1);
    gains("R6", 47, 90);
    zc(1'b1, 1'b0);
    gains("R6", 80, 90);

    // R11 pulse with nothing waiting
    wr(7'd0, 9'h0C0);
    zc(1'b1, 1'b1);
    gains("R11", 80, 90);

    // R8 newest pending code wins
    wr(7'd0, 9'h1C1);
    strobe();
    gains("R8", 80, 90);
    wr(7'd0, 9'h0C2);
    zc(1'b1, 1'b0);
    gains("R8", 66, 90);

    // R7 timeout after 1024 strobes
    wr(7'd0, 9'h1C8);
    strobe();
    for (int i = 0; i < 1023; i++) strobe();
    gains("R7", 66, 90);
    strobe();
    gains("R7", 72, 90);

    // R6 master zero-cross enable applies to both channels
    wr(7'd0, 9'h048);
    wr(7'd2, 9'h1C0);
    strobe();
    gains("R6", 72, 90);
    zc(1'b0, 1'b1);
    gains("R6", 72, 64);
    zc(1'b1, 1'b0);
    gains("R6", 64, 64);
    rd("R5", 7'd2, 'h0C0);
    rd("R5", 7'd1, 'h040);

    // R11 unused address
    wr(7'd5, 9'h1FF);
    rd("R11", 7'd0, 'h040);
    rd("R11", 7'd5, 'h000);
    expect_val("R11", 4, 1);
    strobe();
    gains("R11", 64, 64);

    // R10 power-down
    wr(7'd13, 9'h000);
    expect_val("R10", 4, 0);
    rd("R10", 7'd13, 'h000);
    wr(7'd13, 9'h008);
    expect_val("R10", 4, 1);
    rd("R10", 7'd13, 'h008);

    step(); step();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule